// File: doc/BRIEF.md
# Configurable-format serial character transmitter

This block turns one parallel character into one asynchronous serial frame on a single output line. A character holds 8 or 9 data bits. It can leave the block lowest bit first or highest bit first, and an optional even or odd parity bit can follow the data. With 9 data bits and parity enabled, the frame is 12 bits long: the parity bit sits after the ninth data bit as an extra non-data position.

A producer offers a word with a valid/ready handshake. The block takes the word when it is idle and freezes the format inputs for the whole frame. It then steps through the frame once every 16 pulses of an external oversampling tick. An inversion input flips the entire line, idle level included. The most significant data bit acts as the address-mark position. In highest-first order it is the first bit after the start bit.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset the block is idle: `busy` is 0, `in_ready` is 1, and `tx_out` equals 1 XOR `cfg_invert`.
- R2: A frame is a start bit (0), then the data bits, then the parity bit if enabled, then one stop bit (1). Each bit lasts exactly 16 `tick` pulses, and the start bit appears on the clock edge that accepts the word.
- R3: With `cfg_msb_first`=0, data bit 0 is sent first and the highest data bit is sent last.
- R4: With `cfg_msb_first`=1, the highest data bit is sent first and bit 0 is sent last. The highest data bit is bit 8 when `cfg_nine`=1 and bit 7 when `cfg_nine`=0, and it is the first bit after the start bit.
- R5: When `cfg_par_en`=1, the parity bit follows the last data bit and comes before the stop bit, in either bit order.
- R6: Parity covers all transmitted data bits. `cfg_par_odd`=0 makes the number of ones in data plus parity even. `cfg_par_odd`=1 makes it odd.
- R7: `cfg_nine`=1 sends `in_data[8:0]`, and `cfg_nine`=0 sends `in_data[7:0]`. A frame is therefore 10, 11 or 12 bits long, and `busy` stays 1 until the 16th tick of the stop bit.
- R8: `cfg_invert`=1 inverts every bit of the frame, start and stop bits included, and also inverts the idle level.
- R9: `in_ready` is 1 only while `busy` is 0. A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. While busy, `in_valid` and `in_data` have no effect on the frame in progress.
- R10: The format inputs are sampled at acceptance. Changing them during a frame does not alter that frame.
- R11: A word held valid during a frame is accepted on the first clock edge after `busy` falls, so its start bit follows the previous stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling pulse, one clock wide, 16 per bit |
| in_data | input | 9 | Character to send (bit 8 is used only in 9-bit mode) |
| in_valid | input | 1 | Producer offers `in_data` |
| in_ready | output | 1 | Block can accept a character |
| cfg_nine | input | 1 | 1: 9 data bits, 0: 8 data bits |
| cfg_msb_first | input | 1 | 1: highest data bit first |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_invert | input | 1 | Invert the whole line |
| tx_out | output | 1 | Serial line |
| busy | output | 1 | A frame is being sent |

## Verification
The start bit and `busy` appear right after the accepting clock edge. Each later bit becomes valid on the edge that carries the 16th tick of the bit before it. `busy` drops on the edge of the 16th tick of the stop bit. The bench keeps to this timing by counting ticks from the accepting edge. It samples every bit on the falling clock edge after that bit's 8th tick, so each sample is taken well inside the bit. It checks idle, `in_ready` and the next acceptance on the first falling edges after the end of the frame. The next word and a new format are applied in the middle of each frame, so every later bit also shows that those inputs had no effect.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OSR = 16,
  parameter int DW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          cfg_nine,
  input  logic          cfg_msb_first,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          cfg_invert,
  output logic          tx_out,
  output logic          busy
);
  localparam int FW = DW + 3;
  localparam int TW = $clog2(OSR);
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] shreg, frame_c;
  logic [TW-1:0] tcnt;
  logic [CW-1:0] bidx, last, last_c;
  logic          inv_q;
  logic [DW-1:0] ord, mask;
  logic          par;
  int            nbits;

  assign in_ready = !busy;
  assign tx_out   = (busy ? shreg[0] : 1'b1) ^ (busy ? inv_q : cfg_invert);

  always_comb begin
    nbits = cfg_nine ? DW : DW - 1;
    mask  = cfg_nine ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
    par   = (^(in_data & mask)) ^ cfg_par_odd;
    ord   = '0;
    for (int i = 0; i < DW; i++) begin
      if (i < nbits)
        ord[i] = cfg_msb_first ? in_data[nbits-1-i] : in_data[i];
    end
    frame_c    = '1;
    frame_c[0] = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (i < nbits) frame_c[i+1] = ord[i];
    end
    if (cfg_par_en) frame_c[nbits+1] = par;
    last_c = CW'(nbits + 1) + CW'(cfg_par_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      tcnt  <= '0;
      bidx  <= '0;
      last  <= '0;
      inv_q <= 1'b0;
    end else if (!busy) begin
      if (in_valid) begin
        busy  <= 1'b1;
        shreg <= frame_c;
        last  <= last_c;
        inv_q <= cfg_invert;
        tcnt  <= '0;
        bidx  <= '0;
      end
    end else if (tick) begin
      if (tcnt == TW'(OSR - 1)) begin
        tcnt <= '0;
        if (bidx == last) busy <= 1'b0;
        else begin
          bidx  <= bidx + 1'b1;
          shreg <= {1'b1, shreg[FW-1:1]};
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy);
  p_start_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> tx_out == $past(cfg_invert));
  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tick |=> $stable(tx_out));
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || ($stable(inv_q) && $stable(last)));
  p_ends_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(shreg[0]));
endmodule

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic clk = 0, rst_n = 0, tick = 0;
  logic [8:0] in_data = '0;
  logic in_valid = 0, cfg_nine = 0, cfg_msb_first = 0, cfg_par_en = 0, cfg_par_odd = 0, cfg_invert = 0;
  logic in_ready, tx_out, busy;
  int checks = 0, fails = 0, cyc = 0, tdiv = 0;

  uart_frame_tx u_uart_frame_tx (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == 2) ? 0 : tdiv + 1;
    tick = rst_n && (tdiv == 0);
  end

  typedef struct { logic [8:0] d; logic nine, msb, pe, po, inv; } frm_t;
  logic exp_bits [0:11];
  int   exp_len;

  function automatic void build(frm_t f);
    int n = f.nine ? 9 : 8;
    logic p = f.po;
    exp_bits[0] = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_bits[1+i] = f.msb ? f.d[n-1-i] : f.d[i];
      p ^= f.d[i];
    end
    exp_len = n + 1;
    if (f.pe) begin exp_bits[exp_len] = p; exp_len++; end
    exp_bits[exp_len] = 1'b1;
    exp_len++;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    repeat (n) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  function automatic frm_t pick(int k);
    frm_t f;
    f.d = 9'($urandom); f.nine = 1'($urandom); f.msb = 1'($urandom);
    f.pe = 1'($urandom); f.po = 1'($urandom); f.inv = 1'($urandom);
    case (k)
      0: begin f.d = 9'h000; f.nine = 0; f.msb = 0; f.pe = 1; f.po = 0; f.inv = 0; end
      1: begin f.d = 9'h100; f.nine = 1; f.msb = 1; f.pe = 1; f.po = 1; f.inv = 0; end
      2: begin f.d = 9'h1FF; f.nine = 1; f.msb = 0; f.pe = 1; f.po = 0; f.inv = 1; end
      3: begin f.d = 9'h181; f.nine = 0; f.msb = 1; f.pe = 0; f.po = 0; f.inv = 0; end
      4: begin f.d = 9'h0A5; f.nine = 1; f.msb = 0; f.pe = 0; f.po = 1; f.inv = 1; end
      default: ;
    endcase
    return f;
  endfunction

  task automatic drive(frm_t f);
    in_data = f.d; cfg_nine = f.nine; cfg_msb_first = f.msb;
    cfg_par_en = f.pe; cfg_par_odd = f.po; cfg_invert = f.inv; in_valid = 1;
  endtask

  initial begin
    frm_t cur, nxt;
    string tag;
    int nframes = 105;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 1'b0);
    check("R1 ready", in_ready, 1'b1);
    check("R1 idle", tx_out, 1'b1);
    cfg_invert = 1; #1;
    check("R1 R8 idle inverted", tx_out, 1'b0);
    rst_n = 1;
    @(negedge clk);
    cur = pick(0);
    drive(cur);
    @(posedge clk);
    for (int k = 0; k < nframes; k++) begin
      build(cur);
      @(negedge clk);
      check("R9 busy after accept", busy, 1'b1);
      check("R9 ready low while busy", in_ready, 1'b0);
      in_valid = 0;
      for (int b = 0; b < exp_len; b++) begin
        wait_ticks(8);
        @(negedge clk);
        if (b == 0) tag = "R2 start";
        else if (b == exp_len - 1) tag = "R2 stop";
        else if (cur.pe && b == exp_len - 2) tag = "R5 R6 parity";
        else if (b == 1 && cur.msb) tag = "R4 address mark first";
        else tag = cur.msb ? "R4 R7 data" : "R3 R7 data";
        if (b > 1) tag = {tag, " R10"};
        if (cur.inv) tag = {tag, " R8"};
        check(tag, tx_out, exp_bits[b] ^ cur.inv);
        if (b == exp_len - 1) check("R7 busy through stop", busy, 1'b1);
        if (b == 1 && k + 1 < nframes) begin
          nxt = pick(k + 1);
          drive(nxt);
        end
        wait_ticks(8);
      end
      @(negedge clk);
      check("R7 busy cleared after stop", busy, 1'b0);
      check("R9 ready when idle", in_ready, 1'b1);
      check("R8 R1 idle level", tx_out, 1'b1 ^ cfg_invert);
      if (k + 1 < nframes) begin
        @(posedge clk);
        #1;
        check("R11 back-to-back accept", busy, 1'b1);
        cur = nxt;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule